// File: doc/BRIEF.md
# Vector Widening Left-Shift Unit

This unit performs one vector widening logical left shift over a packed group of lanes in a single pass. A 128-bit source vector is split into elements of a selectable width (8, 16 or 32 bits). Each active element is first zero-extended to twice its width and then shifted left by an unsigned 5-bit immediate. The result is placed in a double-width destination slot, so the packed output is 256 bits wide.

Per-element masking is available. With masking off, every lane is computed. With masking on, lanes whose mask bit is clear are not computed from the source. Under the undisturbed policy such a lane keeps its old destination value, and under the agnostic policy it is written as all ones.

The result and a valid strobe are registered and appear one clock after a valid input. Register-group allocation, overlap legality and instruction decode are handled elsewhere.

Top module: `widen_shift_unit`

## Requirements
- R1: `sewSel` picks the source element width: 2'b00 gives 8 bits (16 lanes), 2'b01 gives 16 bits (8 lanes), and 2'b10 or 2'b11 gives 32 bits (4 lanes). Source element i is `srcVec[i*SEW +: SEW]`, and destination element i is `result[i*2*SEW +: 2*SEW]`.
- R2: Each source element is zero-extended to 2*SEW bits before shifting. With a shift of 0, the upper SEW bits of every active destination element are zero, whatever the element's top bit.
- R3: The shift amount is truncated to log2(2*SEW) bits. For SEW=8 only `shiftImm[3:0]` is used, so `shiftImm[4]` has no effect. For SEW=16 and SEW=32 all 5 bits are used.
- R4: The shift is logical left. Vacated low bits are zero, and bits moved past bit 2*SEW-1 of the element are dropped without spilling into the neighbouring element.
- R5: Element i is active when `maskEn` is 0 or `maskBits[i]` is 1. With `maskEn` at 0, the value of `maskBits` has no effect.
- R6: With `maskAgnostic` at 0, an inactive destination element equals the same slot of `oldDest`.
- R7: With `maskAgnostic` at 1, an inactive destination element is all ones.
- R8: Mask bits at indices at or above the lane count for the selected SEW have no effect on the result.
- R9: `outValid` and `result` reflect an input one clock after the cycle in which `inValid` was high. `outValid` is low after any cycle in which `inValid` was low.
- R10: `result` holds its value across cycles in which `inValid` is low.
- R11: A synchronous active-high `rst` clears `outValid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands valid this cycle |
| srcVec | input | 128 | Packed source elements |
| sewSel | input | 2 | Source element width select |
| shiftImm | input | 5 | Unsigned shift immediate |
| maskBits | input | 16 | Per-element mask, bit i for element i |
| maskEn | input | 1 | Apply the mask when high |
| oldDest | input | 256 | Previous destination contents |
| maskAgnostic | input | 1 | Inactive-lane policy: 1 writes all ones, 0 keeps `oldDest` |
| outValid | output | 1 | Result valid strobe |
| result | output | 256 | Packed widened result |

## Verification
The only internal state is the output register, and any fault in width selection, shift truncation or lane policy is visible on `result` at the first clock after the offending valid input. A wrong lane slice shows up as bits appearing in a neighbouring destination slot. A missing truncation shows up as a zeroed or misplaced element for SEW=8 when `shiftImm[4]` is set. A stuck valid register shows up as `outValid` failing to drop one cycle after `inValid` falls. Every directed case compares the full 256-bit result against a model built from the requirements, so a single wrong bit anywhere in the result is reported.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  parameter int unsigned SRC_W     = 128;
  parameter int unsigned MIN_SEW   = 8;
  parameter int unsigned NUM_SEW   = 3;
  parameter int unsigned IMM_W     = 5;
  parameter int unsigned MAX_LANES = SRC_W / MIN_SEW;
  parameter int unsigned DST_W     = 2 * SRC_W;
  parameter int unsigned SHAMT_W   = $clog2(2 * (MIN_SEW << (NUM_SEW - 1)));

  typedef enum logic [1:0] {
    SEL_E8    = 2'd0,
    SEL_E16   = 2'd1,
    SEL_E32   = 2'd2,
    SEL_E32B  = 2'd3
  } sew_sel_e;

  typedef struct packed {
    logic                 load;
    logic [1:0]           widthIdx;
    logic [SHAMT_W-1:0]   shamt;
    logic [MAX_LANES-1:0] laneOn;
    logic                 agnostic;
  } wsu_ctl_t;
endpackage

// File: rtl/wsu_ctrl.sv
module wsu_ctrl
  import wsu_pkg::*;
(
  input  logic                 inValid,
  input  logic [1:0]           sewSel,
  input  logic [IMM_W-1:0]     shiftImm,
  input  logic [MAX_LANES-1:0] maskBits,
  input  logic                 maskEn,
  input  logic                 maskAgnostic,
  output wsu_ctl_t             ctl
);
  localparam int unsigned E8_SHW = $clog2(2 * MIN_SEW);

  always_comb begin
    ctl.load     = inValid;
    ctl.agnostic = maskAgnostic;
    ctl.laneOn   = maskEn ? maskBits : {MAX_LANES{1'b1}};
    ctl.shamt    = '0;
    unique case (sew_sel_e'(sewSel))
      SEL_E8: begin
        ctl.widthIdx            = 2'd0;
        ctl.shamt[E8_SHW-1:0]   = shiftImm[E8_SHW-1:0];
      end
      SEL_E16: begin
        ctl.widthIdx            = 2'd1;
        ctl.shamt[IMM_W-1:0]    = shiftImm;
      end
      default: begin
        ctl.widthIdx            = 2'd2;
        ctl.shamt[IMM_W-1:0]    = shiftImm;
      end
    endcase
  end
endmodule

// File: rtl/wsu_datapath.sv
module wsu_datapath
  import wsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  wsu_ctl_t         ctl,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [DST_W-1:0] oldDest,
  output logic             outValid,
  output logic [DST_W-1:0] result
);
  logic [DST_W-1:0] cand [NUM_SEW];
  logic [DST_W-1:0] nextResult;

  for (genvar g = 0; g < NUM_SEW; g++) begin : g_width
    localparam int unsigned E    = MIN_SEW << g;
    localparam int unsigned D    = 2 * E;
    localparam int unsigned N    = SRC_W / E;
    localparam int unsigned LOGD = $clog2(D);
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [D-1:0] widened;
      logic [D-1:0] shifted;
      always_comb begin
        widened = {{E{1'b0}}, srcVec[l*E +: E]};
        shifted = widened << ctl.shamt[LOGD-1:0];
        if (ctl.laneOn[l])
          cand[g][l*D +: D] = shifted;
        else if (ctl.agnostic)
          cand[g][l*D +: D] = {D{1'b1}};
        else
          cand[g][l*D +: D] = oldDest[l*D +: D];
      end
    end
  end

  always_comb begin
    unique case (ctl.widthIdx)
      2'd0:    nextResult = cand[0];
      2'd1:    nextResult = cand[1];
      default: nextResult = cand[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) result <= nextResult;
    end
  end
endmodule

// File: rtl/widen_shift_unit.sv
module widen_shift_unit
  import wsu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [SRC_W-1:0]     srcVec,
  input  logic [1:0]           sewSel,
  input  logic [IMM_W-1:0]     shiftImm,
  input  logic [MAX_LANES-1:0] maskBits,
  input  logic                 maskEn,
  input  logic [DST_W-1:0]     oldDest,
  input  logic                 maskAgnostic,
  output logic                 outValid,
  output logic [DST_W-1:0]     result
);
  wsu_ctl_t ctl;

  wsu_ctrl u_ctrl (
    .inValid      (inValid),
    .sewSel       (sewSel),
    .shiftImm     (shiftImm),
    .maskBits     (maskBits),
    .maskEn       (maskEn),
    .maskAgnostic (maskAgnostic),
    .ctl          (ctl)
  );

  wsu_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .srcVec   (srcVec),
    .oldDest  (oldDest),
    .outValid (outValid),
    .result   (result)
  );
endmodule

// File: rtl/wsu_checker.sv
module wsu_checker
  import wsu_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic [SRC_W-1:0]     srcVec,
  input logic [1:0]           sewSel,
  input logic [IMM_W-1:0]     shiftImm,
  input logic [MAX_LANES-1:0] maskBits,
  input logic                 maskEn,
  input logic [DST_W-1:0]     oldDest,
  input logic                 maskAgnostic,
  input logic                 outValid,
  input logic [DST_W-1:0]     result
);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  a_r10_result_holds: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  a_r7_all_masked_ones: assert property (@(posedge clk) disable iff (rst)
    (inValid && maskEn && maskAgnostic && maskBits == '0) |=> (result == '1));

  a_r6_all_masked_old: assert property (@(posedge clk) disable iff (rst)
    (inValid && maskEn && !maskAgnostic && maskBits == '0)
      |=> (result == $past(oldDest)));

  a_r4_zero_source: assert property (@(posedge clk) disable iff (rst)
    (inValid && !maskEn && srcVec == '0) |=> (result == '0));

  a_r2_zero_extend: assert property (@(posedge clk) disable iff (rst)
    (inValid && !maskEn && sewSel == 2'd0 && shiftImm[3:0] == 4'd0)
      |=> (result[15:8] == 8'h00 && result[7:0] == $past(srcVec[7:0])));
endmodule

bind widen_shift_unit wsu_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .inValid      (inValid),
  .srcVec       (srcVec),
  .sewSel       (sewSel),
  .shiftImm     (shiftImm),
  .maskBits     (maskBits),
  .maskEn       (maskEn),
  .oldDest      (oldDest),
  .maskAgnostic (maskAgnostic),
  .outValid     (outValid),
  .result       (result)
);

// File: tb/widen_shift_unit_test.sv
module widen_shift_unit_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [127:0] srcVec;
  logic [1:0]   sewSel;
  logic [4:0]   shiftImm;
  logic [15:0]  maskBits;
  logic         maskEn;
  logic [255:0] oldDest;
  logic         maskAgnostic;
  logic         outValid;
  logic [255:0] result;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  widen_shift_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec),
    .sewSel(sewSel), .shiftImm(shiftImm), .maskBits(maskBits),
    .maskEn(maskEn), .oldDest(oldDest), .maskAgnostic(maskAgnostic),
    .outValid(outValid), .result(result)
  );

  function automatic logic [255:0] model(
    logic [127:0] src, logic [1:0] sel, logic [4:0] imm,
    logic [15:0] m, logic me, logic [255:0] old, logic ag);
    logic [255:0] o;
    int e, n, sh;
    logic [63:0] v;
    o  = '0;
    e  = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
    n  = 128 / e;
    sh = (sel == 2'd0) ? int'(imm[3:0]) : int'(imm);
    for (int i = 0; i < n; i++) begin
      v = (64'(src >> (i * e))) & ((64'd1 << e) - 64'd1);
      v = v << sh;
      for (int b = 0; b < 2 * e; b++) begin
        if (!me || m[i]) o[i*2*e + b] = v[b];
        else             o[i*2*e + b] = ag ? 1'b1 : old[i*2*e + b];
      end
    end
    return o;
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(string tag, logic [127:0] s, logic [1:0] sel,
                       logic [4:0] imm, logic [15:0] m, logic me,
                       logic [255:0] old, logic ag);
    @(negedge clk);
    inValid = 1'b1; srcVec = s; sewSel = sel; shiftImm = imm;
    maskBits = m; maskEn = me; oldDest = old; maskAgnostic = ag;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid"}, {255'd0, outValid}, 256'd1);
    check(tag, result, model(s, sel, imm, m, me, old, ag));
  endtask

  localparam logic [127:0] PAT = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
  localparam logic [255:0] OLD = {8{32'hA5A5_0F0F}};

  task automatic testReset();
    check("R11 reset valid", {255'd0, outValid}, 256'd0);
    check("R11 reset result", result, 256'd0);
  endtask

  task automatic testSew8();
    runOp("R2 sew8 zero-extend shift0", {16{8'hFF}}, 2'd0, 5'd0, 16'h0, 1'b0, OLD, 1'b0);
    runOp("R1 sew8 shift5", PAT, 2'd0, 5'd5, 16'h0, 1'b0, OLD, 1'b0);
    runOp("R4 sew8 shift15 discard", {16{8'hFF}}, 2'd0, 5'd15, 16'h0, 1'b0, OLD, 1'b0);
    runOp("R3 sew8 imm19 acts as 3", PAT, 2'd0, 5'd19, 16'h0, 1'b0, OLD, 1'b0);
    check("R3 sew8 imm19 equals imm3", result, model(PAT, 2'd0, 5'd3, 16'h0, 1'b0, OLD, 1'b0));
  endtask

  task automatic testSew16();
    runOp("R3 sew16 shift17", PAT, 2'd1, 5'd17, 16'h0, 1'b0, OLD, 1'b0);
    runOp("R4 sew16 shift31", {8{16'hFFFF}}, 2'd1, 5'd31, 16'h0, 1'b0, OLD, 1'b0);
    runOp("R2 sew16 top-bit source", {8{16'h8001}}, 2'd1, 5'd0, 16'h0, 1'b0, OLD, 1'b0);
  endtask

  task automatic testSew32();
    runOp("R1 sew32 shift31", PAT, 2'd2, 5'd31, 16'h0, 1'b0, OLD, 1'b0);
    runOp("R1 sel3 as sew32", PAT, 2'd3, 5'd9, 16'h0, 1'b0, OLD, 1'b0);
    check("R1 sel3 equals sel2", result, model(PAT, 2'd2, 5'd9, 16'h0, 1'b0, OLD, 1'b0));
  endtask

  task automatic testMask();
    runOp("R6 undisturbed sew8", PAT, 2'd0, 5'd2, 16'hA5C3, 1'b1, OLD, 1'b0);
    runOp("R7 agnostic sew16", PAT, 2'd1, 5'd4, 16'h0055, 1'b1, OLD, 1'b1);
    runOp("R5 mask disabled ignores bits", PAT, 2'd1, 5'd4, 16'h0000, 1'b0, OLD, 1'b1);
    check("R5 equals unmasked", result, model(PAT, 2'd1, 5'd4, 16'hFFFF, 1'b1, OLD, 1'b1));
    runOp("R8 sew32 high mask bits", PAT, 2'd2, 5'd1, 16'hFFF0, 1'b1, OLD, 1'b0);
    check("R8 sew32 all lanes old", result, OLD);
    runOp("R8 sew16 high mask bits agnostic", PAT, 2'd1, 5'd1, 16'hFF00, 1'b1, OLD, 1'b1);
    check("R8 sew16 all lanes ones", result, {256{1'b1}});
  endtask

  task automatic testHold();
    logic [255:0] snap;
    runOp("R9 op before idle", PAT, 2'd0, 5'd1, 16'h0, 1'b0, OLD, 1'b0);
    snap = result;
    srcVec = ~PAT; shiftImm = 5'd7; oldDest = ~OLD;
    repeat (3) @(negedge clk);
    check("R9 valid low when idle", {255'd0, outValid}, 256'd0);
    check("R10 result held", result, snap);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    inValid = 1'b1; srcVec = PAT; sewSel = 2'd0; shiftImm = 5'd4;
    maskBits = 16'h0; maskEn = 1'b0; oldDest = OLD; maskAgnostic = 1'b0;
    @(negedge clk);
    check("R9 first of pair", result, model(PAT, 2'd0, 5'd4, 16'h0, 1'b0, OLD, 1'b0));
    srcVec = ~PAT; sewSel = 2'd2; shiftImm = 5'd12;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 second of pair valid", {255'd0, outValid}, 256'd1);
    check("R9 second of pair", result, model(~PAT, 2'd2, 5'd12, 16'h0, 1'b0, OLD, 1'b0));
  endtask

  task automatic testMidReset();
    runOp("R11 op before reset", PAT, 2'd1, 5'd3, 16'h0, 1'b0, OLD, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 reset clears result", result, 256'd0);
    check("R11 reset clears valid", {255'd0, outValid}, 256'd0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; srcVec = '0; sewSel = '0; shiftImm = '0;
    maskBits = '0; maskEn = 1'b0; oldDest = '0; maskAgnostic = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testSew8();
    testSew16();
    testSew32();
    testMask();
    testHold();
    testBackToBack();
    testMidReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule